// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is an SPI master that a processor runs through three 32-bit registers: a control/status word, a transmit word and a receive word. Software first loads up to four bytes into the transmit word. It then writes the control word with the start bit set. The control word names the target device, the direction, the byte count, the SCK half-period and a chip-select guard time. The processor polls the busy bit until the transfer is over and then, for a read, fetches the result from the receive word.

A release flag in the control word decides whether the selected chip select goes high when the transfer ends. With the flag clear, the chip select stays low and busy still drops. A long flash command, such as an opcode and address followed by a whole page of data, can therefore be sent as a chain of four-byte register transfers under one unbroken chip select. The serial side uses SPI mode 0.

Top module: `spim_ctrl`

## Requirements
- R1: After reset all chip-select outputs are high, SCK and MOSI are low, and a read of the control word returns 0 (busy clear).
- R2: The control word sits at offset 0x0, the transmit word at 0x4 and the receive word at 0x8. Read data appears on `reg_rdata` one clock after the read strobe. The control word reads back as {busy, six zero bits, the stored bits 24:0}.
- R3: Writing the control word with bit 31 set while idle starts a transfer. Bit 31 reads 1 for as long as it runs and 0 once it has ended. Writing with bit 31 clear only stores the fields.
- R4: A write to the control word while busy changes neither the stored fields nor the running transfer.
- R5: Bits 24:23 pick the chip; only `spi_cs_n[chip]` goes low, from the clock edge that takes the start write onward.
- R6: Bits 12:8 give a guard count G. After the start edge, CS is low with SCK and MOSI low for G+1 clocks. Only then is the first data bit presented.
- R7: Bits 18:13 give a half-period P in clocks, with 0 taken as 1. SCK idles low, spends P clocks low and then P clocks high per bit, and makes 8*(N+1) pulses, where N is bits 20:19.
- R8: In a write (bits 22:21 = 0), bits go out MSB-first from the transmit word starting at bit 31. MOSI changes only when SCK falls and holds while SCK is high.
- R9: In a read (bits 22:21 = 1), MOSI stays low. MISO is sampled on each rising SCK edge. The received bits are packed into the receive word from bit 31 downward, and the unused low bits are 0.
- R10: Bit 0 of the control word is the release flag. Set (value 0x01): after the last falling SCK edge CS stays low for G+1 more clocks, then all CS go high and busy clears at that same edge. Clear (0x00): busy clears at the last falling SCK edge and CS stays low for the next transfer.
- R11: The transmit word is captured at the start. Writing it during a transfer updates the register but does not change the bits going out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after `reg_rd` |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bound checker looks at every cycle. It checks that at most one chip select is low, that SCK is low whenever the block is idle, and that MOSI is steady while SCK is high and low throughout a read. It also checks that a start always raises busy, that control writes during a transfer leave the stored fields alone, and that chip select is never released while busy.
Exact cycle counts for the guard and half-period timing, bit order on MOSI, the packing of received bytes, the ignored transmit update and the continued chip select across chained transfers are shown only by the bench's scenarios. These are compared against its per-clock expected waveform and its register reads.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W   = 32;
  localparam int CHIP_W   = 2;
  localparam int OP_W     = 2;
  localparam int NBYTE_W  = 2;
  localparam int HALF_W   = 6;
  localparam int GUARD_W  = 5;
  localparam int CSCTL_W  = 8;
  localparam int CFG_W    = CHIP_W + OP_W + NBYTE_W + HALF_W + GUARD_W + CSCTL_W;
  localparam int BIT_IDX_W = $clog2(WORD_W);

  localparam int OFS_CTRL = 'h0;
  localparam int OFS_TX   = 'h4;
  localparam int OFS_RX   = 'h8;

  localparam logic [OP_W-1:0] OP_READ = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } spim_state_e;

  typedef struct packed {
    logic [CHIP_W-1:0]  chip;
    logic [OP_W-1:0]    op;
    logic [NBYTE_W-1:0] nbytes_m1;
    logic [HALF_W-1:0]  half;
    logic [GUARD_W-1:0] guard;
    logic [CSCTL_W-1:0] csctl;
  } spim_cfg_t;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] rdata,
  output logic              ctrl_wr,
  output logic              start,
  output spim_cfg_t         start_cfg,
  output spim_cfg_t         cfg_q,
  output logic [WORD_W-1:0] tx_word
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(OFS_TX);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(OFS_RX);
  localparam int RSV_W = WORD_W - 1 - CFG_W;

  logic unused_rsv;
  assign unused_rsv = ^wdata[WORD_W-2:CFG_W];

  assign ctrl_wr   = wr && (addr == A_CTRL);
  assign start     = ctrl_wr && wdata[WORD_W-1] && !busy;
  assign start_cfg = spim_cfg_t'(wdata[CFG_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      tx_word <= '0;
      rdata   <= '0;
    end else begin
      if (ctrl_wr && !busy) cfg_q <= start_cfg;
      if (wr && addr == A_TX) tx_word <= wdata;
      if (rd) begin
        if (addr == A_CTRL)    rdata <= {busy, {RSV_W{1'b0}}, cfg_q};
        else if (addr == A_TX) rdata <= tx_word;
        else if (addr == A_RX) rdata <= rx_word;
        else                   rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/spim_sck_timer.sv
module spim_sck_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  logic [CNT_W-1:0] hp_cnt;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = (half == '0) ? '0 : half - CNT_W'(1);
  assign tick     = run && (hp_cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst || !run)  hp_cnt <= '0;
    else if (tick)    hp_cnt <= '0;
    else              hp_cnt <= hp_cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  spim_cfg_t         start_cfg,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  input  logic              tick,
  output logic              run,
  output logic [HALF_W-1:0] half,
  output logic              busy,
  output logic              rd_op,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n,
  output logic [WORD_W-1:0] rx_word
);
  spim_state_e          state;
  spim_cfg_t            cfg;
  logic [GUARD_W-1:0]   gcnt;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic [BIT_IDX_W-1:0] last_idx;
  logic [WORD_W-1:0]    tx_sh;
  logic [WORD_W-1:0]    rx_sh;
  logic [WORD_W-1:0]    rx_next;
  logic [BIT_IDX_W-1:0] align;
  logic                 phase_hi;
  logic                 release_cs;
  logic                 unused_csctl;

  assign unused_csctl = ^cfg.csctl[CSCTL_W-1:1];
  assign run        = (state == ST_SHIFT);
  assign half       = cfg.half;
  assign rd_op      = (cfg.op == OP_READ);
  assign release_cs = cfg.csctl[0];
  assign last_idx   = {cfg.nbytes_m1, 3'b111};
  assign align      = {~cfg.nbytes_m1, 3'b000};
  assign rx_next    = {rx_sh[WORD_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cfg      <= '0;
      gcnt     <= '0;
      bit_idx  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      phase_hi <= 1'b0;
      busy     <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      cs_n     <= '1;
      rx_word  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cfg   <= start_cfg;
            tx_sh <= tx_word;
            rx_sh <= '0;
            gcnt  <= '0;
            busy  <= 1'b1;
            cs_n  <= ~(NUM_CS'(1) << start_cfg.chip);
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (gcnt == cfg.guard) begin
            state    <= ST_SHIFT;
            phase_hi <= 1'b0;
            bit_idx  <= '0;
            mosi     <= rd_op ? 1'b0 : tx_sh[WORD_W-1];
          end else begin
            gcnt <= gcnt + GUARD_W'(1);
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!phase_hi) begin
              sclk     <= 1'b1;
              phase_hi <= 1'b1;
              rx_sh    <= rx_next;
            end else begin
              sclk     <= 1'b0;
              phase_hi <= 1'b0;
              if (bit_idx == last_idx) begin
                mosi <= 1'b0;
                if (rd_op) rx_word <= rx_sh << align;
                if (release_cs) begin
                  gcnt  <= '0;
                  state <= ST_HOLD;
                end else begin
                  busy  <= 1'b0;
                  state <= ST_IDLE;
                end
              end else begin
                bit_idx <= bit_idx + BIT_IDX_W'(1);
                tx_sh   <= tx_sh << 1;
                mosi    <= rd_op ? 1'b0 : tx_sh[WORD_W-2];
              end
            end
          end
        end
        ST_HOLD: begin
          if (gcnt == cfg.guard) begin
            cs_n  <= '1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            gcnt <= gcnt + GUARD_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic              busy;
  logic              ctrl_wr;
  logic              start;
  logic              run;
  logic              tick;
  logic              eng_rd_op;
  logic [HALF_W-1:0] half;
  logic [WORD_W-1:0] tx_word;
  logic [WORD_W-1:0] rx_word;
  spim_cfg_t         start_cfg;
  spim_cfg_t         cfg_q;

  spim_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .rx_word(rx_word), .rdata(reg_rdata),
    .ctrl_wr(ctrl_wr), .start(start), .start_cfg(start_cfg), .cfg_q(cfg_q),
    .tx_word(tx_word)
  );

  spim_sck_timer #(.CNT_W(HALF_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .half(half), .tick(tick)
  );

  spim_engine #(.NUM_CS(NUM_CS)) u_engine (
    .clk(clk), .rst(rst), .start(start), .start_cfg(start_cfg),
    .tx_word(tx_word), .miso(spi_miso), .tick(tick), .run(run), .half(half),
    .busy(busy), .rd_op(eng_rd_op), .sclk(spi_sclk), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .rx_word(rx_word)
  );
endmodule

// File: rtl/spim_ctrl_sva.sv
module spim_ctrl_sva
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              start,
  input logic              ctrl_wr,
  input spim_cfg_t         cfg_q,
  input logic              rd_op,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n
);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  p_busy_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr) |=> $stable(cfg_q));

  p_one_select_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  p_mosi_steady_r8: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  p_mosi_low_read_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_op) |-> !mosi);

  p_release_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cs_n != '1));
endmodule

bind spim_ctrl spim_ctrl_sva #(.NUM_CS(NUM_CS)) u_sva (
  .clk(clk), .rst(rst), .busy(busy), .start(start), .ctrl_wr(ctrl_wr),
  .cfg_q(cfg_q), .rd_op(eng_rd_op), .sclk(spi_sclk), .mosi(spi_mosi),
  .cs_n(spi_cs_n)
);

// File: tb/spim_ctrl_test.sv
`timescale 1ns/1ps
module spim_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk;
  logic        spi_mosi;
  logic [3:0]  spi_cs_n;
  logic [31:0] miso_pat = '0;
  logic        spi_miso;

  int n_checks = 0;
  int n_fails  = 0;
  bit cmp_en   = 1'b0;
  logic [5:0] exp_q[$];
  logic [5:0] exp_now = 6'b111100;

  always #2.5 clk = ~clk;
  assign spi_miso = miso_pat[31];
  always @(negedge spi_sclk) miso_pat <= miso_pat << 1;

  spim_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock reference: expected {cs_n, sclk, mosi} (R5 R6 R7 R8 R9 R10)
  always @(negedge clk) begin
    if (cmp_en) begin
      if (exp_q.size() > 0) exp_now = exp_q.pop_front();
      check({spi_cs_n, spi_sclk, spi_mosi} === exp_now, "R5 R6 R7 R8 R9 R10 pins",
            32'({spi_cs_n, spi_sclk, spi_mosi}), 32'(exp_now));
    end
  end

  function automatic logic [31:0] ctrl_word(bit go, int chip, bit rd, int nb,
                                            int half, int guard, bit rel);
    return {go, 6'b0, 2'(chip), 2'(rd), 2'(nb), 6'(half), 5'(guard), 8'(rel)};
  endfunction

  task automatic push_xfer(int chip, bit rd, int nb, int half, int guard,
                           bit rel, logic [31:0] tx);
    logic [3:0] cs = ~(4'b0001 << chip);
    int p = (half == 0) ? 1 : half;
    for (int i = 0; i <= guard; i++) exp_q.push_back({cs, 2'b00});
    for (int b = 0; b < 8 * (nb + 1); b++) begin
      logic bv = rd ? 1'b0 : tx[31 - b];
      for (int k = 0; k < p; k++) exp_q.push_back({cs, 1'b0, bv});
      for (int k = 0; k < p; k++) exp_q.push_back({cs, 1'b1, bv});
    end
    if (rel) begin
      for (int i = 0; i <= guard; i++) exp_q.push_back({cs, 2'b00});
      exp_q.push_back(6'b111100);
    end else begin
      exp_q.push_back({cs, 2'b00});
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic start_xfer(int chip, bit rd, int nb, int half, int guard,
                            bit rel, logic [31:0] tx);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h0;
    reg_wdata = ctrl_word(1'b1, chip, rd, nb, half, guard, rel);
    @(posedge clk); #1;
    reg_wr = 1'b0;
    push_xfer(chip, rd, nb, half, guard, rel, tx);
  endtask

  task automatic wait_done(logic [31:0] exp_ctrl);
    logic [31:0] d;
    while (exp_q.size() > 0) @(negedge clk);
    bus_read(4'h0, d);
    check(d === exp_ctrl, "R3 busy clear and R2 readback", d, exp_ctrl);
  endtask

  task automatic run_all();
    logic [31:0] d;
    logic [31:0] w;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check({spi_cs_n, spi_sclk, spi_mosi} === 6'b111100, "R1 pins after reset",
          32'({spi_cs_n, spi_sclk, spi_mosi}), 32'h3c);
    cmp_en = 1'b1;
    bus_read(4'h0, d);
    check(d === 32'h0, "R1 control after reset", d, 32'h0);

    // R2: transmit word readback
    bus_write(4'h4, 32'hA5C33C5A);
    bus_read(4'h4, d);
    check(d === 32'hA5C33C5A, "R2 tx readback", d, 32'hA5C33C5A);

    // R3 R6 R8 R10: one byte write, chip 0, release
    start_xfer(0, 0, 0, 16, 2, 1, 32'hA5C33C5A);
    bus_read(4'h0, d);
    check(d[31] === 1'b1, "R3 busy while running", 32'(d[31]), 32'h1);
    wait_done(ctrl_word(1'b0, 0, 0, 0, 16, 2, 1));

    // R4 R11: four-byte write, chip 2, keep CS low; disturb during transfer
    bus_write(4'h4, 32'h0123CDEF);
    start_xfer(2, 0, 3, 1, 0, 0, 32'h0123CDEF);
    repeat (10) @(negedge clk);
    bus_write(4'h0, ctrl_word(1'b1, 0, 1, 1, 9, 7, 1));
    bus_write(4'h4, 32'hFFFF0000);
    w = ctrl_word(1'b0, 2, 0, 3, 1, 0, 0);
    wait_done(w);
    check(spi_cs_n === 4'b1011, "R10 CS kept low without release",
          32'(spi_cs_n), 32'hb);
    bus_read(4'h4, d);
    check(d === 32'hFFFF0000, "R11 tx register updated", d, 32'hFFFF0000);

    // R10: continuation on chip 2, two bytes, then release
    start_xfer(2, 0, 1, 3, 1, 1, 32'hFFFF0000);
    wait_done(ctrl_word(1'b0, 2, 0, 1, 3, 1, 1));

    // R9: one-byte read, chip 1
    miso_pat = 32'h9E000000;
    start_xfer(1, 1, 0, 2, 3, 1, 32'hFFFF0000);
    wait_done(ctrl_word(1'b0, 1, 1, 0, 2, 3, 1));
    bus_read(4'h8, d);
    check(d === 32'h9E000000, "R9 one-byte read packing", d, 32'h9E000000);

    // R7 R9: four-byte read, chip 3, half-period 0 acts as 1
    miso_pat = 32'hC3A51F60;
    start_xfer(3, 1, 3, 0, 0, 1, 32'hFFFF0000);
    wait_done(ctrl_word(1'b0, 3, 1, 3, 0, 0, 1));
    bus_read(4'h8, d);
    check(d === 32'hC3A51F60, "R9 four-byte read", d, 32'hC3A51F60);

    // R9: three-byte read leaves low byte zero
    miso_pat = 32'h5AF00FFF;
    start_xfer(0, 1, 2, 5, 1, 1, 32'hFFFF0000);
    wait_done(ctrl_word(1'b0, 0, 1, 2, 5, 1, 1));
    bus_read(4'h8, d);
    check(d === 32'h5AF00F00, "R9 three-byte read", d, 32'h5AF00F00);

    // R3: control write without start bit stores fields only
    w = ctrl_word(1'b0, 3, 0, 2, 7, 4, 0);
    bus_write(4'h0, w);
    repeat (20) @(negedge clk);
    bus_read(4'h0, d);
    check(d === w, "R3 store without start", d, w);
    check(spi_cs_n === 4'hF, "R3 no transfer without start", 32'(spi_cs_n), 32'hF);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule